// File: doc/BRIEF.md
# Vectored interrupt daisy-chain controller

This block collects interrupt events from a two-channel serial cell and a four-channel DMA cell, keeps pending, in-service and enable state for every source, and joins an external priority chain through an enable-in (`iei`) and enable-out (`ieo`) pair. It drives an interrupt request, resolves priority when the host acknowledges, marks the winning source as in service and returns an 8-bit vector. That vector is either the programmed value or the value with a 3-bit source code spliced into bits 3..1. Events arrive as one-cycle pulses. The bus read is reduced to an acknowledge level (`intack`) and a read strobe (`rd_stb`).

The serial cell has six sources. Each serial channel has a receive, a transmit and an external/status source. The DMA cell has one source per channel. Each DMA source keeps one pending bit and one in-service bit, which its terminal-count and abort events share. Each of those two events has its own enable.

The acknowledge sequencer is a four-state machine:
- `S_IDLE`: no acknowledge is in progress.
- `S_HOLD`: status-style acknowledge, waiting for the read strobe.
- `S_ARMED`: double-pulse acknowledge, waiting for the second pulse.
- `S_DRAIN`: the vector has been delivered and the machine waits for `intack` to fall.

Its transitions are:
- From `S_IDLE`, `intack` high in status style goes to `S_HOLD`.
- From `S_IDLE`, a rising `intack` in single style delivers and goes to `S_DRAIN`.
- From `S_IDLE`, a rising `intack` in double style goes to `S_ARMED`.
- From `S_HOLD`, `rd_stb` with `intack` high delivers and goes to `S_DRAIN`.
- From `S_HOLD`, `intack` low returns to `S_IDLE`.
- From `S_ARMED`, a rising `intack` delivers and goes to `S_DRAIN`.
- From `S_DRAIN`, `intack` low returns to `S_IDLE`.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: After reset, no source is pending or in service, `irq` and `vec_vld` are low and `ieo` equals `iei`.
- R2: A serial pending bit is set on the clock after its event pulse only if that source's enable is high in the pulse cycle. It stays set until the matching `ser_clr_pend` bit is pulsed.
- R3: A DMA pending bit is set by a terminal-count or abort pulse whatever the enables are. The source requests only while the enable of an event that set it is high. Both events share one in-service bit.
- R4: While a cell's master enable is low, none of that cell's sources requests. The pending state is kept and requests again once the master enable returns.
- R5: `irq` is high exactly when `iei` is high and some requesting source has no in-service bit set at its own or any higher priority.
- R6: Priority runs from high to low in this order: serial A receive, A transmit, A external, then serial B receive, B transmit, B external. DMA channels follow in the order 0, 1, 2, 3. Source indices follow the same order: serial 0..5, DMA 0..3. DMA channels 0 to 3 stand for receive A, transmit A, receive B and transmit B.
- R7: A delivery sets the in-service bit of the highest-priority unblocked requester. That bit stays set until a `clr_ius` pulse, which clears only the highest-priority in-service bit.
- R8: `ieo` is high only when `iei` is high, no in-service bit is set and no source requests while an acknowledge is active. An acknowledge is active when `intack` is high or the sequencer is not in `S_IDLE`.
- R9: `vec_vld` pulses for one cycle on the clock after a delivery. With the cell's vector-include bit low, `vec_o` is that cell's programmed vector. With the bit high, bits 3..1 are replaced by a code. The serial codes are A receive 110, A special receive 111, A transmit 100, A external 101, B receive 010, B special receive 011, B transmit 000 and B external 001. The DMA code is the channel number.
- R10: `ack_mode` 00 or 11 selects status style, where the vector comes on `rd_stb` while `intack` is high. 01 selects single pulse, where the vector comes on the rising edge of `intack`. 10 selects double pulse, where the vector comes on the second rising edge.
- R11: A delivery while `iei` is low, or while no source is unblocked and requesting, gives no `vec_vld` and sets no in-service bit.
- R12: An event and a pending clear for the same source in the same cycle leave the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_ev | input | 6 | Serial event pulses, index per R6 |
| ser_spec | input | 2 | Special-receive flag per serial channel, qualifies a receive event |
| ser_ie | input | 6 | Serial source enables |
| ser_mie | input | 1 | Serial cell master enable |
| ser_clr_pend | input | 6 | Serial pending-clear pulses |
| dma_tc | input | 4 | DMA terminal-count event pulses |
| dma_abort | input | 4 | DMA abort event pulses |
| dma_tc_ie | input | 4 | DMA terminal-count enables |
| dma_abort_ie | input | 4 | DMA abort enables |
| dma_mie | input | 1 | DMA cell master enable |
| dma_clr_pend | input | 4 | DMA pending-clear pulses |
| ser_vec | input | 8 | Serial cell programmed vector |
| dma_vec | input | 8 | DMA cell programmed vector |
| ser_vis | input | 1 | Serial vector-include-source select |
| dma_vis | input | 1 | DMA vector-include-source select |
| ack_mode | input | 2 | Acknowledge style per R10 |
| intack | input | 1 | Acknowledge cycle level, active high |
| rd_stb | input | 1 | Vector read strobe for status style |
| clr_ius | input | 1 | Pulse clearing the highest-priority in-service bit |
| iei | input | 1 | Chain enable in |
| irq | output | 1 | Interrupt request, active high |
| ieo | output | 1 | Chain enable out |
| vec_o | output | 8 | Returned vector |
| vec_vld | output | 1 | One-cycle vector valid |

## Verification
The assertions assume the following about the inputs. Event, clear and strobe inputs are single-cycle pulses. `rd_stb` only matters while `intack` is high. No mode change happens in the middle of an acknowledge. The bench drives every input half a cycle away from the active edge and holds each pulse for exactly one cycle. It changes `ack_mode` only while the sequencer is idle, and it raises `rd_stb` only in the cycle after `intack` went high. It keeps `clr_ius` away from delivery cycles, except where a scenario targets a specific rule.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;

    localparam int SER_CH   = 2;
    localparam int SER_KIND = 3;
    localparam int N_SER    = SER_CH * SER_KIND;
    localparam int DMA_CH   = 4;
    localparam int N_SRC    = N_SER + DMA_CH;
    localparam int CODE_W   = 3;

    typedef enum logic [1:0] {
        ACK_STATUS     = 2'b00,
        ACK_SINGLE     = 2'b01,
        ACK_DOUBLE     = 2'b10,
        ACK_STATUS_ALT = 2'b11
    } ack_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_ARMED,
        S_DRAIN
    } ack_state_e;

    // Serial source code: bit 2 marks channel A, low bits give the type.
    function automatic logic [CODE_W-1:0] ser_code(input int ch, input int kind, input logic spec);
        logic chan_a;
        chan_a = (ch == 0);
        case (kind)
            0:       return {chan_a, 1'b1, spec};
            1:       return {chan_a, 2'b00};
            default: return {chan_a, 2'b01};
        endcase
    endfunction

endpackage

// File: rtl/irq_ser_src.sv
module irq_ser_src
    import irq_daisy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SER-1:0]  ev,
    input  logic [SER_CH-1:0] spec_ev,
    input  logic [N_SER-1:0]  ie,
    input  logic              mie,
    input  logic [N_SER-1:0]  clr_pend,
    input  logic [N_SER-1:0]  set_ius,
    input  logic [N_SER-1:0]  clr_ius,
    output logic [N_SER-1:0]  pend,
    output logic [N_SER-1:0]  ius,
    output logic [N_SER-1:0]  req,
    output logic [SER_CH-1:0] spec_q
);

    for (genvar i = 0; i < N_SER; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (ev[i] && ie[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_pend[i]) begin
                pend[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ius[i] <= 1'b0;
            end else if (set_ius[i]) begin
                ius[i] <= 1'b1;
            end else if (clr_ius[i]) begin
                ius[i] <= 1'b0;
            end
        end

        assert_ser_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(ie[i]));

        assert_ser_ius_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ius[i]) && !$past(clr_ius[i])) |-> ius[i]);
    end

    for (genvar c = 0; c < SER_CH; c++) begin : g_spec
        localparam int RX = c * SER_KIND;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                spec_q[c] <= 1'b0;
            end else if (ev[RX] && ie[RX]) begin
                spec_q[c] <= spec_ev[c];
            end else if (clr_pend[RX]) begin
                spec_q[c] <= 1'b0;
            end
        end
    end

    assign req = pend & ie & {N_SER{mie}};

endmodule

// File: rtl/irq_dma_src.sv
module irq_dma_src
    import irq_daisy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DMA_CH-1:0] tc,
    input  logic [DMA_CH-1:0] ab,
    input  logic [DMA_CH-1:0] tc_ie,
    input  logic [DMA_CH-1:0] ab_ie,
    input  logic              mie,
    input  logic [DMA_CH-1:0] clr_pend,
    input  logic [DMA_CH-1:0] set_ius,
    input  logic [DMA_CH-1:0] clr_ius,
    output logic [DMA_CH-1:0] ius,
    output logic [DMA_CH-1:0] req
);

    logic [DMA_CH-1:0] pend;
    logic [DMA_CH-1:0] tc_seen;
    logic [DMA_CH-1:0] ab_seen;

    for (genvar c = 0; c < DMA_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[c]    <= 1'b0;
                tc_seen[c] <= 1'b0;
                ab_seen[c] <= 1'b0;
            end else if (tc[c] || ab[c]) begin
                pend[c]    <= 1'b1;
                tc_seen[c] <= tc_seen[c] | tc[c];
                ab_seen[c] <= ab_seen[c] | ab[c];
            end else if (clr_pend[c]) begin
                pend[c]    <= 1'b0;
                tc_seen[c] <= 1'b0;
                ab_seen[c] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ius[c] <= 1'b0;
            end else if (set_ius[c]) begin
                ius[c] <= 1'b1;
            end else if (clr_ius[c]) begin
                ius[c] <= 1'b0;
            end
        end

        assert_dma_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[c]) |-> $past(tc[c] || ab[c]));

        assert_dma_ius_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ius[c]) && !$past(clr_ius[c])) |-> ius[c]);
    end

    assign req = pend & ((tc_seen & tc_ie) | (ab_seen & ab_ie)) & {DMA_CH{mie}};

endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain
    import irq_daisy_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] ius,
    output logic [N_SRC-1:0] win_oh,
    output logic [N_SRC-1:0] ius_top_oh,
    output logic             any_ok,
    output logic             any_req,
    output logic             any_ius
);

    logic [N_SRC-1:0] blk;
    logic [N_SRC-1:0] ok;
    logic [N_SRC-1:0] ok_above;
    logic [N_SRC-1:0] ius_above;

    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        if (i == 0) begin : g_head
            assign blk[i]       = ius[i];
            assign ok_above[i]  = 1'b0;
            assign ius_above[i] = 1'b0;
        end else begin : g_tail
            assign blk[i]       = blk[i-1] | ius[i];
            assign ok_above[i]  = ok_above[i-1] | ok[i-1];
            assign ius_above[i] = ius_above[i-1] | ius[i-1];
        end
        assign ok[i]         = req[i] & ~blk[i];
        assign win_oh[i]     = ok[i] & ~ok_above[i];
        assign ius_top_oh[i] = ius[i] & ~ius_above[i];
    end

    assign any_ok  = |ok;
    assign any_req = |req;
    assign any_ius = |ius;

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_daisy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       intack,
    input  logic       rd_stb,
    output logic       deliver,
    output logic       ack_active
);

    ack_state_e state_q;
    ack_state_e state_d;
    ack_mode_e  mode;
    logic       intack_q;
    logic       rise;

    assign mode = ack_mode_e'(mode_i);
    assign rise = intack & ~intack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            intack_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            intack_q <= intack;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                unique case (mode)
                    ACK_SINGLE:                 if (rise) state_d = S_DRAIN;
                    ACK_DOUBLE:                 if (rise) state_d = S_ARMED;
                    ACK_STATUS, ACK_STATUS_ALT: if (intack) state_d = S_HOLD;
                endcase
            end
            S_HOLD: begin
                if (rd_stb && intack) state_d = S_DRAIN;
                else if (!intack)     state_d = S_IDLE;
            end
            S_ARMED: if (rise)    state_d = S_DRAIN;
            S_DRAIN: if (!intack) state_d = S_IDLE;
        endcase
    end

    always_comb begin
        deliver = 1'b0;
        unique case (state_q)
            S_IDLE:  deliver = (mode == ACK_SINGLE) && rise;
            S_HOLD:  deliver = rd_stb && intack;
            S_ARMED: deliver = rise;
            S_DRAIN: deliver = 1'b0;
        endcase
        ack_active = intack || (state_q != S_IDLE);
    end

    assert_one_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> !deliver);

endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
    import irq_daisy_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       ser_ev,
    input  logic [1:0]       ser_spec,
    input  logic [5:0]       ser_ie,
    input  logic             ser_mie,
    input  logic [5:0]       ser_clr_pend,
    input  logic [3:0]       dma_tc,
    input  logic [3:0]       dma_abort,
    input  logic [3:0]       dma_tc_ie,
    input  logic [3:0]       dma_abort_ie,
    input  logic             dma_mie,
    input  logic [3:0]       dma_clr_pend,
    input  logic [VEC_W-1:0] ser_vec,
    input  logic [VEC_W-1:0] dma_vec,
    input  logic             ser_vis,
    input  logic             dma_vis,
    input  logic [1:0]       ack_mode,
    input  logic             intack,
    input  logic             rd_stb,
    input  logic             clr_ius,
    input  logic             iei,
    output logic             irq,
    output logic             ieo,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld
);

    localparam logic [VEC_W-1:0] CODE_MASK = VEC_W'({CODE_W{1'b1}}) << CODE_LSB;

    logic [N_SRC-1:0]  req;
    logic [N_SRC-1:0]  ius;
    logic [N_SRC-1:0]  win_oh;
    logic [N_SRC-1:0]  ius_top_oh;
    logic [N_SRC-1:0]  set_ius;
    logic [N_SRC-1:0]  drop_ius;
    logic [N_SER-1:0]  ser_pend;
    logic [SER_CH-1:0] spec_q;
    logic              any_ok;
    logic              any_req;
    logic              any_ius;
    logic              deliver;
    logic              ack_active;
    logic              grant;
    logic [CODE_W-1:0] code;
    logic [VEC_W-1:0]  base;
    logic              vis;
    logic [VEC_W-1:0]  vec_d;

    assign grant    = deliver && iei && any_ok;
    assign set_ius  = grant ? win_oh : '0;
    assign drop_ius = clr_ius ? ius_top_oh : '0;

    irq_ser_src u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ser_ev),
        .spec_ev  (ser_spec),
        .ie       (ser_ie),
        .mie      (ser_mie),
        .clr_pend (ser_clr_pend),
        .set_ius  (set_ius[N_SER-1:0]),
        .clr_ius  (drop_ius[N_SER-1:0]),
        .pend     (ser_pend),
        .ius      (ius[N_SER-1:0]),
        .req      (req[N_SER-1:0]),
        .spec_q   (spec_q)
    );

    irq_dma_src u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (dma_tc),
        .ab       (dma_abort),
        .tc_ie    (dma_tc_ie),
        .ab_ie    (dma_abort_ie),
        .mie      (dma_mie),
        .clr_pend (dma_clr_pend),
        .set_ius  (set_ius[N_SRC-1:N_SER]),
        .clr_ius  (drop_ius[N_SRC-1:N_SER]),
        .ius      (ius[N_SRC-1:N_SER]),
        .req      (req[N_SRC-1:N_SER])
    );

    irq_prio_chain u_prio (
        .req        (req),
        .ius        (ius),
        .win_oh     (win_oh),
        .ius_top_oh (ius_top_oh),
        .any_ok     (any_ok),
        .any_req    (any_req),
        .any_ius    (any_ius)
    );

    irq_ack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (ack_mode),
        .intack     (intack),
        .rd_stb     (rd_stb),
        .deliver    (deliver),
        .ack_active (ack_active)
    );

    always_comb begin
        code = '0;
        base = dma_vec;
        vis  = dma_vis;
        for (int i = 0; i < N_SER; i++) begin
            if (win_oh[i]) begin
                code = ser_code(i / SER_KIND, i % SER_KIND, spec_q[i / SER_KIND]);
                base = ser_vec;
                vis  = ser_vis;
            end
        end
        for (int c = 0; c < DMA_CH; c++) begin
            if (win_oh[N_SER + c]) begin
                code = CODE_W'(c);
            end
        end
        vec_d = vis ? ((base & ~CODE_MASK) | (VEC_W'(code) << CODE_LSB)) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o   <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= grant;
            if (grant) vec_o <= vec_d;
        end
    end

    assign irq = iei && any_ok;
    assign ieo = iei && !any_ius && !(ack_active && any_req);

    assert_vec_needs_iei_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(iei));

    assert_vec_marks_ius_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> (|ius));

    assert_vec_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |=> !vec_vld);

    assert_pend_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ev[0] && ser_ie[0]) |=> ser_pend[0]);

endmodule

// File: tb/test_irq_daisy_ctrl.sv
`timescale 1ns/1ps
module test_irq_daisy_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ser_ev = '0, ser_ie = '0, ser_clr_pend = '0;
    logic [1:0] ser_spec = '0, ack_mode = '0;
    logic       ser_mie = 1'b0, dma_mie = 1'b0;
    logic [3:0] dma_tc = '0, dma_abort = '0, dma_tc_ie = '0, dma_abort_ie = '0, dma_clr_pend = '0;
    logic [7:0] ser_vec = '0, dma_vec = '0;
    logic       ser_vis = 1'b0, dma_vis = 1'b0;
    logic       intack = 1'b0, rd_stb = 1'b0, clr_ius = 1'b0, iei = 1'b1;
    logic       irq, ieo, vec_vld;
    logic [7:0] vec_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_daisy_ctrl i_irq_daisy_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_ev(ser_ev), .ser_spec(ser_spec), .ser_ie(ser_ie),
        .ser_mie(ser_mie), .ser_clr_pend(ser_clr_pend), .dma_tc(dma_tc), .dma_abort(dma_abort),
        .dma_tc_ie(dma_tc_ie), .dma_abort_ie(dma_abort_ie), .dma_mie(dma_mie),
        .dma_clr_pend(dma_clr_pend), .ser_vec(ser_vec), .dma_vec(dma_vec), .ser_vis(ser_vis),
        .dma_vis(dma_vis), .ack_mode(ack_mode), .intack(intack), .rd_stb(rd_stb),
        .clr_ius(clr_ius), .iei(iei), .irq(irq), .ieo(ieo), .vec_o(vec_o), .vec_vld(vec_vld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ser_pulse(input int idx, input logic [1:0] spec);
        ser_ev[idx] = 1'b1; ser_spec = spec; tick();
        ser_ev = '0; ser_spec = '0;
    endtask

    task automatic ser_clear(input int idx);
        ser_clr_pend[idx] = 1'b1; tick(); ser_clr_pend = '0;
    endtask

    task automatic dma_clear(input int idx);
        dma_clr_pend[idx] = 1'b1; tick(); dma_clr_pend = '0;
    endtask

    task automatic drop_ius();
        clr_ius = 1'b1; tick(); clr_ius = 1'b0;
    endtask

    task automatic ack_status(output logic v, output logic [7:0] vec);
        ack_mode = 2'b00; intack = 1'b1; tick();
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        v = vec_vld; vec = vec_o;
        intack = 1'b0; tick();
    endtask

    task automatic ack_single(output logic v, output logic [7:0] vec);
        ack_mode = 2'b01; intack = 1'b1; tick();
        v = vec_vld; vec = vec_o;
        intack = 1'b0; tick();
    endtask

    task automatic ack_double(output logic v, output logic [7:0] vec);
        ack_mode = 2'b10; intack = 1'b1; tick();
        chk("R10 no vector after first pulse", vec_vld, 1'b0);
        intack = 1'b0; tick();
        intack = 1'b1; tick();
        v = vec_vld; vec = vec_o;
        intack = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 ieo after reset", ieo, 1'b1);
        chk("R1 vec_vld after reset", vec_vld, 1'b0);
    endtask

    task automatic t_ser_gate();
        ser_mie = 1'b1; ser_ie = '0;
        ser_pulse(0, 2'b00);
        chk("R2 disabled event not pending", irq, 1'b0);
        ser_ie = 6'b000001; tick();
        chk("R2 enabling later raises nothing", irq, 1'b0);
        ser_pulse(0, 2'b00);
        chk("R5 enabled pending raises irq", irq, 1'b1);
        ser_clear(0);
        chk("R2 clear drops pending", irq, 1'b0);
        ser_ie = 6'h3F;
    endtask

    task automatic t_dma();
        logic v; logic [7:0] vec;
        dma_mie = 1'b1; dma_tc_ie = '0; dma_abort_ie = '0;
        dma_tc[1] = 1'b1; tick(); dma_tc = '0;
        chk("R3 pending held without enable", irq, 1'b0);
        dma_tc_ie[1] = 1'b1; tick();
        chk("R3 enable exposes held pending", irq, 1'b1);
        dma_vis = 1'b1; dma_vec = 8'hA0;
        ack_status(v, vec);
        chk("R10 status-style vector valid", v, 1'b1);
        chk("R9 DMA channel 1 code", vec, 8'hA2);
        chk("R8 ieo low while in service", ieo, 1'b0);
        chk("R7 own in-service blocks", irq, 1'b0);
        dma_abort[1] = 1'b1; tick(); dma_abort = '0;
        chk("R3 abort shares in-service", irq, 1'b0);
        drop_ius();
        chk("R7 clear re-exposes pending", irq, 1'b1);
        dma_clear(1);
        chk("R3 clear DMA pending", irq, 1'b0);
        dma_tc_ie = 4'hF; dma_abort_ie = '0;
        dma_abort[2] = 1'b1; tick(); dma_abort = '0;
        chk("R3 abort enable is separate", irq, 1'b0);
        dma_abort_ie[2] = 1'b1; tick();
        chk("R3 abort enable exposes", irq, 1'b1);
        dma_clear(2);
        chk("R1 chain idle again", ieo, 1'b1);
    endtask

    task automatic t_prio();
        logic v; logic [7:0] vec;
        ser_vis = 1'b1; ser_vec = 8'h00;
        ser_ev[4] = 1'b1; ser_ev[2] = 1'b1; dma_tc[0] = 1'b1; tick();
        ser_ev = '0; dma_tc = '0;
        ack_single(v, vec);
        chk("R10 single-pulse vector valid", v, 1'b1);
        chk("R6 A external beats B transmit and DMA", vec, 8'h0A);
        chk("R5 lower sources blocked", irq, 1'b0);
        ser_pulse(0, 2'b00);
        chk("R5 higher source nests", irq, 1'b1);
        ack_double(v, vec);
        chk("R10 double-pulse vector valid", v, 1'b1);
        chk("R6 A receive code", vec, 8'h0C);
        drop_ius();
        chk("R7 only top in-service cleared", ieo, 1'b0);
        chk("R7 A receive pending unblocked", irq, 1'b1);
        ser_clear(0);
        chk("R7 A external still blocks", irq, 1'b0);
        drop_ius();
        chk("R7 second clear reopens", irq, 1'b1);
        ser_clear(2);
        ser_vis = 1'b0; ser_vec = 8'h55;
        ack_status(v, vec);
        chk("R9 programmed vector unchanged", vec, 8'h55);
        drop_ius(); ser_clear(4);
        dma_vec = 8'hF1;
        ack_status(v, vec);
        chk("R6 DMA channel 0 last", vec, 8'hF1);
        drop_ius(); dma_clear(0);
        chk("R1 all idle", irq, 1'b0);
    endtask

    task automatic t_special();
        logic v; logic [7:0] vec;
        ser_vis = 1'b1; ser_vec = 8'hF1;
        ser_pulse(3, 2'b10);
        ack_single(v, vec);
        chk("R9 B special receive code", vec, 8'hF7);
        drop_ius(); ser_clear(3);
        ser_pulse(3, 2'b00);
        ack_single(v, vec);
        chk("R9 B plain receive code", vec, 8'hF5);
        drop_ius(); ser_clear(3);
    endtask

    task automatic t_ieo();
        logic v; logic [7:0] vec;
        ser_pulse(5, 2'b00);
        chk("R8 ieo high outside acknowledge", ieo, 1'b1);
        ack_mode = 2'b11; intack = 1'b1; tick();
        chk("R8 ieo low when requesting in acknowledge", ieo, 1'b0);
        chk("R5 irq during acknowledge", irq, 1'b1);
        intack = 1'b0; tick();
        chk("R8 ieo back high", ieo, 1'b1);
        iei = 1'b0; tick();
        chk("R5 irq low with iei low", irq, 1'b0);
        chk("R8 ieo low with iei low", ieo, 1'b0);
        ack_single(v, vec);
        chk("R11 no vector with iei low", v, 1'b0);
        iei = 1'b1; tick();
        chk("R11 no in-service set", irq, 1'b1);
        ser_clear(5);
        ack_single(v, vec);
        chk("R11 no vector without request", v, 1'b0);
        chk("R11 ieo high after empty acknowledge", ieo, 1'b1);
    endtask

    task automatic t_mie();
        ser_pulse(1, 2'b00);
        ser_mie = 1'b0; tick();
        chk("R4 master enable masks", irq, 1'b0);
        ser_mie = 1'b1; tick();
        chk("R4 pending kept", irq, 1'b1);
        ser_clear(1);
    endtask

    task automatic t_race();
        ser_ev[1] = 1'b1; ser_clr_pend[1] = 1'b1; tick();
        ser_ev = '0; ser_clr_pend = '0;
        chk("R12 set wins over clear", irq, 1'b1);
        ser_clear(1);
        chk("R12 plain clear works", irq, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_ser_gate();
        t_dma();
        t_prio();
        t_special();
        t_ieo();
        t_mie();
        t_race();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule